// File: doc/BRIEF.md
# Quadrature Down-Converter with Two-Level CIC Decimation

This block turns a stream of real intermediate-frequency samples into decimated complex baseband pairs. Every master clock brings one signed 12-bit converter sample. A 32-bit phase accumulator, advanced by a tuning word, selects a local-oscillator phase. Two multipliers mix the sample into an in-phase path and a quadrature path. Each path then passes through a two-stage cascaded integrator-comb decimator and after that a five-stage one. The two decimation ratios are set independently.

Each decimated pair is scaled, rounded and saturated to 16 bits, then shifted out on a serial port that the block drives itself. The block generates the bit clock from the master clock through an even divisor. It raises a one-bit frame marker and then sends I and Q, most significant bit first. The receiver only samples. A pair that arrives while the previous frame is still waiting or in flight is discarded, and a sticky flag records the loss.

Top module: `ddc_cic_rx`

## Requirements
- R1: While `rst` is high, `ser_clk`, `ser_frame`, `ser_data` and `overrun` are all low.
- R2: For a sample x and a local-oscillator phase index k (0..7), the mixer produces I = floor(x·C(k)/2^15) and Q = floor(−x·C((k+6) mod 8)/2^15). The table C(0..7) is 32767, 23170, 0, −23170, −32767, −23170, 0, 23170. With a zero tuning word and a constant input of 1000, the settled frames carry I = 999 and Q = 0.
- R3: The phase accumulator is zero after reset and adds `tune_word` modulo 2^32 on every clock. Sample t after reset uses phase t·tune_word, and k is taken from phase bits [31:29].
- R4: The first decimator is a two-stage CIC with ratio `dec1_ratio` (2..16). It emits one output after every dec1_ratio-th mixer sample, counted from reset. Output m is the second difference, taken at spacing dec1_ratio, of the twofold running sum of the mixer samples, read two samples before sample (m+1)·dec1_ratio−1. All history before reset is zero.
- R5: The second decimator has the same form with five stages, ratio `dec2_ratio` (1..32) and a five-sample read lag. Its input is the stream of first-decimator outputs.
- R6: Each decimator output is scaled by an arithmetic right shift of N·floor(log2 R), where N is the stage count and R the ratio. When the shift is not zero, 2^(shift−1) is added first. The result then saturates to [−32768, 32767].
- R7: A frame is `ser_frame` high for exactly one bit period, then 32 data bits: I[15] down to I[0], then Q[15] down to Q[0]. The line returns low after the last bit.
- R8: `ser_clk` has a period of `sclk_div` master clocks (even, at least 2) with equal high and low halves. `ser_frame` and `ser_data` change only in the cycle in which `ser_clk` falls, so the receiver samples on the rising edge.
- R9: A pair that arrives while a frame is pending or being sent is dropped, and `overrun` goes high and stays high until reset. The frames that are sent are still exact, in order.
- R10: When the pair period, dec1_ratio·dec2_ratio clocks, is at least 35·sclk_div, every pair is sent in order and `overrun` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, shared with the converter |
| rst | input | 1 | Synchronous active-high reset |
| adc_sample | input | 12 | Signed converter sample, one per clock |
| tune_word | input | 32 | Phase increment per clock |
| dec1_ratio | input | 5 | First decimator ratio, 2..16 |
| dec2_ratio | input | 6 | Second decimator ratio, 1..32 |
| sclk_div | input | 8 | Even bit-clock divisor, at least 2 |
| ser_clk | output | 1 | Serial bit clock driven by the block |
| ser_frame | output | 1 | One-bit frame marker ahead of each frame |
| ser_data | output | 1 | Serial data, most significant bit first |
| overrun | output | 1 | Sticky flag: a pair was dropped |

## Verification
The mixer registers its product one clock after the sample. Each decimator registers its output one clock after its decimating input. The serializer then waits for the next falling edge of `ser_clk` to raise the frame marker, and the data follows on the 32 falling edges after that. Because that wait depends on the bit-clock phase, the bench decodes `ser_clk` on every master clock at the falling master edge and compares each completed frame with a queue filled by a behavioural model. It also checks the bit-clock period at every rising edge. So results are checked at the exact bit where they appear, with no fixed-latency guess.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    // Index of the highest set bit (0 for an input of 0 or 1).
    function automatic int flog2(input logic [7:0] r);
        int res;
        res = 0;
        for (int i = 0; i < 8; i++) begin
            if (r[i]) res = i;
        end
        return res;
    endfunction

    // Eight-phase cosine in Q15; sine is taken as cosine two steps back.
    function automatic logic signed [15:0] lo_cos(input logic [2:0] k);
        case (k)
            3'd0:    return 16'sd32767;
            3'd1:    return 16'sd23170;
            3'd2:    return 16'sd0;
            3'd3:    return -16'sd23170;
            3'd4:    return -16'sd32767;
            3'd5:    return -16'sd23170;
            3'd6:    return 16'sd0;
            default: return 16'sd23170;
        endcase
    endfunction

endpackage

// File: rtl/ddc_mixer.sv
module ddc_mixer #(
    parameter int IN_W = 12,
    parameter int PH_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] adc,
    input  logic [PH_W-1:0] tune,
    output logic            out_valid,
    output logic [IN_W-1:0] out_i,
    output logic [IN_W-1:0] out_q
);
    localparam int LO_W = 16;

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            vld;
        logic [IN_W-1:0] i;
        logic [IN_W-1:0] q;
    } mix_t;

    mix_t s_d, s_q;
    logic signed [LO_W-1:0]      cos_v, sin_v;
    logic signed [IN_W+LO_W-1:0] prod_i, prod_q;

    always_comb begin
        s_d     = s_q;
        cos_v   = ddc_pkg::lo_cos(s_q.phase[PH_W-1 -: 3]);
        sin_v   = ddc_pkg::lo_cos(s_q.phase[PH_W-1 -: 3] + 3'd6);
        prod_i  = $signed(adc) * cos_v;
        prod_q  = $signed(adc) * (-sin_v);
        s_d.phase = s_q.phase + tune;
        s_d.vld   = 1'b1;
        s_d.i     = IN_W'(prod_i >>> (LO_W - 1));
        s_d.q     = IN_W'(prod_q >>> (LO_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_i     = s_q.i;
    assign out_q     = s_q.q;

    // R3: phase moves by exactly the tuning word each clock
    p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> s_q.phase == $past(s_q.phase) + $past(tune));

endmodule

// File: rtl/ddc_cic.sv
module ddc_cic #(
    parameter int N     = 2,
    parameter int IN_W  = 12,
    parameter int OUT_W = 16,
    parameter int RW    = 5,
    parameter int GROW  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RW-1:0]    ratio,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    localparam int W = IN_W + GROW;
    localparam logic signed [W:0] SAT_HI = (W+1)'(2**(OUT_W-1) - 1);
    localparam logic signed [W:0] SAT_LO = -SAT_HI - (W+1)'(1);

    typedef struct packed {
        logic [N-1:0][W-1:0] integ;
        logic [N-1:0][W-1:0] dly;
        logic [RW-1:0]       cnt;
        logic                vld;
        logic [OUT_W-1:0]    dat;
    } cic_t;

    cic_t s_d, s_q;
    logic [N:0][W-1:0] comb_w;
    logic signed [W:0] ext, rnd, shr;
    int                sh;

    always_comb begin
        // comb chain on the last integrator value, spaced by the delays
        comb_w[0] = s_q.integ[N-1];
        for (int k = 1; k <= N; k++) begin
            comb_w[k] = comb_w[k-1] - s_q.dly[k-1];
        end
        // scale, round half up, saturate
        sh  = N * ddc_pkg::flog2(8'(ratio));
        ext = $signed({comb_w[N][W-1], comb_w[N]});
        rnd = (sh == 0) ? ext : ext + ((W+1)'(1) << (sh - 1));
        shr = rnd >>> sh;

        s_d     = s_q;
        s_d.vld = 1'b0;
        if (in_valid) begin
            s_d.integ[0] = s_q.integ[0] + {{GROW{in_data[IN_W-1]}}, in_data};
            for (int k = 1; k < N; k++) begin
                s_d.integ[k] = s_q.integ[k] + s_q.integ[k-1];
            end
            if (s_q.cnt >= ratio - RW'(1)) begin
                s_d.cnt = '0;
                s_d.vld = 1'b1;
                for (int k = 0; k < N; k++) begin
                    s_d.dly[k] = comb_w[k];
                end
                if (shr > SAT_HI)      s_d.dat = OUT_W'(SAT_HI);
                else if (shr < SAT_LO) s_d.dat = OUT_W'(SAT_LO);
                else                   s_d.dat = OUT_W'(shr);
            end else begin
                s_d.cnt = s_q.cnt + RW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_data  = s_q.dat;

    // R4 / R5: an output strobe only follows an accepted input
    p_strobe_after_input_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

endmodule

// File: rtl/ddc_ser_tx.sv
module ddc_ser_tx #(
    parameter int DW    = 16,
    parameter int DIV_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DIV_W-1:0] div,
    input  logic            in_valid,
    input  logic [2*DW-1:0] in_data,
    output logic            ser_clk,
    output logic            ser_frame,
    output logic            ser_data,
    output logic            overrun
);
    localparam int FRAME_BITS = 2 * DW;
    localparam int BC_W       = $clog2(FRAME_BITS + 2);

    typedef struct packed {
        logic                  sclk;
        logic                  fs;
        logic                  sd;
        logic                  busy;
        logic                  ovr;
        logic [BC_W-1:0]       bitc;
        logic [DIV_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] sh;
    } ser_t;

    ser_t s_d, s_q;
    logic [DIV_W-1:0] half;
    logic             fall;

    always_comb begin
        half = ((div >> 1) == '0) ? DIV_W'(1) : (div >> 1);
        s_d  = s_q;
        fall = 1'b0;
        if (s_q.cnt >= half - DIV_W'(1)) begin
            s_d.cnt  = '0;
            s_d.sclk = ~s_q.sclk;
            fall     = s_q.sclk;
        end else begin
            s_d.cnt = s_q.cnt + DIV_W'(1);
        end

        if (fall && s_q.busy) begin
            if (s_q.bitc == '0) begin
                s_d.fs   = 1'b1;
                s_d.sd   = 1'b0;
                s_d.bitc = BC_W'(1);
            end else if (s_q.bitc <= BC_W'(FRAME_BITS)) begin
                s_d.fs   = 1'b0;
                s_d.sd   = s_q.sh[FRAME_BITS-1];
                s_d.sh   = {s_q.sh[FRAME_BITS-2:0], 1'b0};
                s_d.bitc = s_q.bitc + BC_W'(1);
            end else begin
                s_d.fs   = 1'b0;
                s_d.sd   = 1'b0;
                s_d.busy = 1'b0;
            end
        end

        if (in_valid) begin
            if (!s_q.busy) begin
                s_d.busy = 1'b1;
                s_d.bitc = '0;
                s_d.sh   = in_data;
            end else begin
                s_d.ovr  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ser_clk   = s_q.sclk;
    assign ser_frame = s_q.fs;
    assign ser_data  = s_q.sd;
    assign overrun   = s_q.ovr;

    // R8: data and marker move only as the bit clock falls
    p_data_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_data) |-> $fell(ser_clk));
    p_frame_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_frame) |-> $fell(ser_clk));
    // R7: marker never lasts two bit periods
    p_frame_one_bit_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(ser_clk) && $past(ser_frame)) |-> !ser_frame);
    // R9: overrun flag is sticky
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

// File: rtl/ddc_cic_rx.sv
module ddc_cic_rx #(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 16,
    parameter int PH_W   = 32,
    parameter int N1     = 2,
    parameter int N2     = 5,
    parameter int MAX_R1 = 16,
    parameter int MAX_R2 = 32,
    parameter int R1_W   = $clog2(MAX_R1 + 1),
    parameter int R2_W   = $clog2(MAX_R2 + 1),
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  adc_sample,
    input  logic [PH_W-1:0]  tune_word,
    input  logic [R1_W-1:0]  dec1_ratio,
    input  logic [R2_W-1:0]  dec2_ratio,
    input  logic [DIV_W-1:0] sclk_div,
    output logic             ser_clk,
    output logic             ser_frame,
    output logic             ser_data,
    output logic             overrun
);
    localparam int GROW1 = N1 * $clog2(MAX_R1);
    localparam int GROW2 = N2 * $clog2(MAX_R2);

    logic                       mix_vld;
    logic [1:0][IN_W-1:0]       mix;
    logic [1:0]                 c1_vld, c2_vld;
    logic [1:0][OUT_W-1:0]      c1_dat, c2_dat;

    ddc_mixer #(.IN_W(IN_W), .PH_W(PH_W)) u_mix (
        .clk(clk), .rst(rst), .adc(adc_sample), .tune(tune_word),
        .out_valid(mix_vld), .out_i(mix[0]), .out_q(mix[1])
    );

    for (genvar g = 0; g < 2; g++) begin : g_path
        ddc_cic #(.N(N1), .IN_W(IN_W), .OUT_W(OUT_W), .RW(R1_W), .GROW(GROW1)) u_cic1 (
            .clk(clk), .rst(rst), .ratio(dec1_ratio),
            .in_valid(mix_vld), .in_data(mix[g]),
            .out_valid(c1_vld[g]), .out_data(c1_dat[g])
        );
        ddc_cic #(.N(N2), .IN_W(OUT_W), .OUT_W(OUT_W), .RW(R2_W), .GROW(GROW2)) u_cic2 (
            .clk(clk), .rst(rst), .ratio(dec2_ratio),
            .in_valid(c1_vld[g]), .in_data(c1_dat[g]),
            .out_valid(c2_vld[g]), .out_data(c2_dat[g])
        );
    end

    ddc_ser_tx #(.DW(OUT_W), .DIV_W(DIV_W)) u_ser (
        .clk(clk), .rst(rst), .div(sclk_div),
        .in_valid(c2_vld[0] & c2_vld[1]), .in_data({c2_dat[0], c2_dat[1]}),
        .ser_clk(ser_clk), .ser_frame(ser_frame), .ser_data(ser_data), .overrun(overrun)
    );

    // R1: outputs idle while reset is applied
    always @(posedge clk) begin
        if (rst && $past(rst)) begin
            p_reset_idle_r1: assert (!ser_clk && !ser_frame && !ser_data && !overrun);
        end
    end

endmodule

// File: tb/ddc_cic_rx_test.sv
`timescale 1ns/1ps
module ddc_cic_rx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] adc = '0;
    logic [31:0] tune = '0;
    logic [4:0]  dec1 = 5'd8;
    logic [5:0]  dec2 = 6'd16;
    logic [7:0]  sdiv = 8'd2;
    logic        ser_clk, ser_frame, ser_data, overrun;

    always #4 clk = ~clk;

    ddc_cic_rx uut (
        .clk(clk), .rst(rst), .adc_sample(adc), .tune_word(tune),
        .dec1_ratio(dec1), .dec2_ratio(dec2), .sclk_div(sdiv),
        .ser_clk(ser_clk), .ser_frame(ser_frame), .ser_data(ser_data), .overrun(overrun)
    );

    int nchk = 0;
    int nerr = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    longint      acc  [2][2][5];
    longint      hist [2][2][5];
    longint      prv  [2][2][5];
    int          c1n, c2n;
    logic [31:0] ph;
    logic [31:0] exp_q [$];

    function automatic int lg(input int r);
        int l = 0;
        while ((1 << (l + 1)) <= r) l++;
        return l;
    endfunction

    function automatic longint locos(input int k);
        case (k)
            0: return 32767;  1: return 23170;  2: return 0;      3: return -23170;
            4: return -32767; 5: return -23170; 6: return 0;      default: return 23170;
        endcase
    endfunction

    function automatic longint scl(input longint y, input int sh);
        longint v = y;
        if (sh > 0) v = (v + (64'sd1 <<< (sh - 1))) >>> sh;
        if (v > 32767)  v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    task automatic cic_model(input int c, input int p, input int n, input longint x,
                             input bit dec, input int r, output longint y);
        longint v, d, t;
        acc[c][p][0] += x;
        for (int k = 1; k < n; k++) acc[c][p][k] += acc[c][p][k-1];
        v = hist[c][p][n-1];
        for (int k = n - 1; k > 0; k--) hist[c][p][k] = hist[c][p][k-1];
        hist[c][p][0] = acc[c][p][n-1];
        y = 0;
        if (dec) begin
            d = v;
            for (int k = 0; k < n; k++) begin
                t = d;
                d = d - prv[c][p][k];
                prv[c][p][k] = t;
            end
            y = scl(d, n * lg(r));
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < 2; a++)
                for (int b = 0; b < 2; b++)
                    for (int k = 0; k < 5; k++) begin
                        acc[a][b][k] = 0; hist[a][b][k] = 0; prv[a][b][k] = 0;
                    end
            c1n = 0; c2n = 0; ph = '0;
            exp_q.delete();
        end else begin
            longint sx, xi, xq, yi, yq, zi, zq;
            int     k;
            bit     d1, d2;
            sx = longint'($signed(adc));
            k  = int'(ph[31:29]);
            xi = (sx * locos(k)) >>> 15;
            xq = (sx * (-locos((k + 6) % 8))) >>> 15;
            ph = ph + tune;
            d1  = (c1n == int'(dec1) - 1);
            c1n = d1 ? 0 : c1n + 1;
            cic_model(0, 0, 2, xi, d1, int'(dec1), yi);
            cic_model(0, 1, 2, xq, d1, int'(dec1), yq);
            if (d1) begin
                d2  = (c2n == int'(dec2) - 1);
                c2n = d2 ? 0 : c2n + 1;
                cic_model(1, 0, 5, yi, d2, int'(dec2), zi);
                cic_model(1, 1, 5, yq, d2, int'(dec2), zq);
                if (d2) exp_q.push_back({zi[15:0], zq[15:0]});
            end
        end
    end

    // ---------------- serial receiver, decoded every clock ----------------
    bit          ovr_mode = 1'b0;
    bit          in_frame, have_rise, prev_sclk;
    int          nb, cyc, last_rise, rx_frames, skipped;
    logic [31:0] word, last_word, e;

    always @(negedge clk) begin
        if (rst) begin
            in_frame = 0; have_rise = 0; prev_sclk = 0;
            nb = 0; cyc = 0; rx_frames = 0; skipped = 0;
        end else begin
            cyc++;
            if (ser_clk && !prev_sclk) begin
                if (have_rise)
                    check(cyc - last_rise == int'(sdiv), "R8 bit period",
                          32'(cyc - last_rise), 32'(sdiv));
                have_rise = 1; last_rise = cyc;
                if (ser_frame) begin
                    if (in_frame) check(0, "R7 marker inside frame", 32'(nb), 32'd32);
                    in_frame = 1; nb = 0; word = '0;
                end else if (in_frame) begin
                    word = {word[30:0], ser_data};
                    nb++;
                    if (nb == 32) begin
                        in_frame = 0;
                        rx_frames++;
                        last_word = word;
                        if (!ovr_mode) begin
                            if (exp_q.size() == 0) check(0, "R10 unexpected frame", word, '0);
                            else begin
                                e = exp_q.pop_front();
                                check(word == e, "R4 R5 R6 R7 frame", word, e);
                            end
                        end else begin
                            while (exp_q.size() > 0 && exp_q[0] != word) begin
                                void'(exp_q.pop_front());
                                skipped++;
                            end
                            if (exp_q.size() == 0) check(0, "R9 frame not in produced order", word, '0);
                            else begin
                                e = exp_q.pop_front();
                                check(1'b1, "R9 frame", word, e);
                            end
                        end
                    end
                end
            end
            prev_sclk = ser_clk;
        end
    end

    // ---------------- stimulus ----------------
    logic [15:0] lfsr = 16'hACE1;

    task automatic run_case(input logic [31:0] tw, input int r1v, input int r2v, input int divv,
                            input bit rnd, input logic [11:0] cval, input int nfr, input bit om);
        @(negedge clk);
        rst = 1'b1;
        tune = tw; dec1 = 5'(r1v); dec2 = 6'(r2v); sdiv = 8'(divv);
        adc = cval; ovr_mode = om;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        while (rx_frames < nfr) begin
            @(negedge clk);
            if (rnd) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                adc  = lfsr[11:0];
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        // R1: idle outputs during reset
        repeat (3) @(negedge clk);
        check(!ser_clk,   "R1 ser_clk in reset",   32'(ser_clk),   0);
        check(!ser_frame, "R1 ser_frame in reset", 32'(ser_frame), 0);
        check(!ser_data,  "R1 ser_data in reset",  32'(ser_data),  0);
        check(!overrun,   "R1 overrun in reset",   32'(overrun),   0);

        // R2: dc input, no rotation, unity-gain ratios
        run_case(32'h0, 8, 16, 2, 1'b0, 12'd1000, 12, 1'b0);
        check(last_word == {16'd999, 16'd0}, "R2 settled dc pair", last_word, {16'd999, 16'd0});
        check(!overrun, "R10 no overrun", 32'(overrun), 0);

        // R3: eighth-turn per clock with random samples
        run_case(32'h2000_0000, 4, 32, 2, 1'b1, 12'd0, 12, 1'b0);
        check(!overrun, "R10 no overrun", 32'(overrun), 0);

        // R3 R6: arbitrary tuning, odd ratios (shift not matching gain)
        run_case(32'h1357_9BDF, 3, 32, 2, 1'b1, 12'd0, 12, 1'b0);
        run_case(32'h0BAD_F00D, 9, 11, 2, 1'b1, 12'd0, 10, 1'b0);
        check(!overrun, "R10 no overrun", 32'(overrun), 0);

        // R6: positive and negative saturation
        run_case(32'h0, 16, 7, 2, 1'b0, 12'h7FF, 12, 1'b0);
        check(last_word == 32'h7FFF_0000, "R6 positive saturation", last_word, 32'h7FFF_0000);
        run_case(32'h0, 16, 7, 2, 1'b0, 12'h800, 12, 1'b0);
        check(last_word == 32'h8000_0000, "R6 negative saturation", last_word, 32'h8000_0000);

        // R8: larger divisor
        run_case(32'h0400_0000, 16, 16, 6, 1'b1, 12'd0, 8, 1'b0);
        check(!overrun, "R10 no overrun", 32'(overrun), 0);

        // R9: pairs far faster than frames
        run_case(32'h0300_0000, 2, 1, 40, 1'b1, 12'd0, 3, 1'b1);
        check(overrun, "R9 overrun raised", 32'(overrun), 1);
        check(skipped > 0, "R9 pairs dropped", 32'(skipped), 1);
        repeat (50) @(negedge clk);
        check(overrun, "R9 overrun held", 32'(overrun), 1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule